// File: doc/BRIEF.md
# UART In-Band Flow Controller

This block runs character-based (Xon/Xoff) flow control for one UART channel. On the receive side it watches the receive FIFO occupancy against a trigger level picked from two fixed tables, one for a 16-entry FIFO and one for a 64-entry FIFO. When occupancy reaches the trigger it raises an interrupt and asks the transmitter to insert the programmed Xoff character. When occupancy drains to a lower level, which is given by a second table, it asks for the Xon character. The gap between the two levels gives hysteresis.

On the transmit side it inspects every received character. A match with the Xoff character pauses the local transmitter, and only a match with the Xon character releases it. The pause takes effect only between characters. Both comparisons use the programmed word length of 5 to 8 bits.

The serializer, the FIFOs and the baud generator sit outside this block. A synchronous clear returns all state to idle. A flow-control enable suppresses insertions and the pause output without discarding the remote pause state.

Top module: `uart_xonxoff_ctrl`

## Requirements
- R1: With `deep_mode`=0, the trigger level for `trig_sel` 0,1,2,3 is 1,4,8,14. `rx_irq` is 1 in the cycle after any cycle in which `fifo_level` is at or above the trigger, and 0 otherwise.
- R2: With `deep_mode`=1, the trigger level for `trig_sel` 0,1,2,3 is 8,16,56,60, with the same `rx_irq` timing as R1.
- R3: While enabled, with no request outstanding and no Xoff recorded as sent, a level at or above the trigger raises `ins_req` with `ins_char`=`xoff_char` in the next cycle. Once that request is acknowledged, the block records Xoff as sent and issues no further Xoff until an Xon has been sent.
- R4: While an Xoff is recorded as sent, a level at or below the release level raises an Xon request (`ins_char`=`xon_char`). The release level is 0,1,4,8 in 16-entry mode and 0,8,16,56 in 64-entry mode, indexed by `trig_sel`.
- R5: An insertion request and its character stay unchanged until the cycle in which `ins_ack` is 1. `ins_req` is 0 in the cycle after that acknowledge.
- R6: Received characters are compared only in their low bits. `wlen` 0,1,2,3 selects 5,6,7,8 compared bits, and the upper bits are ignored.
- R7: A received character (`rx_valid`=1) that matches Xoff sets the remote pause state, and one that matches Xon clears it. If a character matches both, Xoff wins. `tx_pause` follows this state two cycles after the strobe, provided the transmitter is between characters.
- R8: While `tx_char_busy` is 1, `tx_pause` keeps its value. A change takes effect in the cycle after `tx_char_busy` returns to 0.
- R9: With `fc_en`=0, `ins_req` and `tx_pause` are 0 and received characters are ignored. A pause state held before disabling reappears on `tx_pause` as soon as `fc_en` returns to 1.
- R10: `sw_clr`=1 clears the request, the sent-Xoff record, the remote pause state, `tx_pause` and `rx_irq` in the next cycle.
- R11: After reset, `ins_req`, `ins_char`, `tx_pause` and `rx_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_clr | input | 1 | Synchronous clear of all controller state |
| fc_en | input | 1 | Flow-control enable |
| deep_mode | input | 1 | 0 = 16-entry tables, 1 = 64-entry tables |
| trig_sel | input | 2 | Trigger level select |
| wlen | input | 2 | Compared character width: 5 + wlen bits |
| xon_char | input | 8 | Programmed Xon character |
| xoff_char | input | 8 | Programmed Xoff character |
| fifo_level | input | LVL_W | Receive FIFO occupancy |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| tx_char_busy | input | 1 | Transmitter is in the middle of a character |
| ins_ack | input | 1 | Transmitter accepts the insertion request |
| ins_req | output | 1 | Request to insert a flow-control character |
| ins_char | output | 8 | Character to insert |
| tx_pause | output | 1 | Hold the local transmitter at the next character boundary |
| rx_irq | output | 1 | Receive trigger interrupt |

## Verification
On every cycle the assertions check four things: that a pending insertion keeps its character until acknowledged and drops right after the acknowledge, that the pause output stays frozen while a character is in flight, that an empty FIFO never raises the interrupt, and that a clear empties the outputs. The exact trigger and release thresholds of both tables, the word-length masking, the Xoff-over-Xon precedence and the retention of the pause state across disable are shown only by the bench. It does this with directed scenarios and with a per-cycle reference model under random level walks, acknowledges, received characters and mode changes.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

  // Trigger (interrupt / Xoff) level for the selected FIFO depth.
  function automatic int unsigned trig_level(input logic deep, input logic [1:0] sel);
    int unsigned v;
    if (deep) begin
      case (sel)
        2'd0:    v = 8;
        2'd1:    v = 16;
        2'd2:    v = 56;
        default: v = 60;
      endcase
    end else begin
      case (sel)
        2'd0:    v = 1;
        2'd1:    v = 4;
        2'd2:    v = 8;
        default: v = 14;
      endcase
    end
    return v;
  endfunction

  // Release (Xon) level: occupancy must fall to this value or below.
  function automatic int unsigned release_level(input logic deep, input logic [1:0] sel);
    int unsigned v;
    if (deep) begin
      case (sel)
        2'd0:    v = 0;
        2'd1:    v = 8;
        2'd2:    v = 16;
        default: v = 56;
      endcase
    end else begin
      case (sel)
        2'd0:    v = 0;
        2'd1:    v = 1;
        2'd2:    v = 4;
        default: v = 8;
      endcase
    end
    return v;
  endfunction

  // Compare mask for a 5..8 bit character.
  function automatic logic [7:0] char_mask(input logic [1:0] wlen);
    return 8'hFF >> (2'd3 - wlen);
  endfunction

endpackage

// File: rtl/xfc_rst_sync.sv
module xfc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xfc_level_ctrl.sv
module xfc_level_ctrl #(
  parameter int LVL_W  = 7,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_clr,
  input  logic              fc_en,
  input  logic              deep_mode,
  input  logic [1:0]        trig_sel,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              ins_ack,
  output logic              ins_req,
  output logic [CHAR_W-1:0] ins_char,
  output logic              rx_irq
);
  logic [LVL_W-1:0]  trig_v, rel_v;
  logic              req_q, req_n;
  logic              kind_q, kind_n;   // 1 = Xoff pending, 0 = Xon pending
  logic              sent_q, sent_n;   // Xoff recorded as sent
  logic [CHAR_W-1:0] char_q, char_n;
  logic              irq_q, irq_n;
  logic              above, below;

  assign trig_v = LVL_W'(xfc_pkg::trig_level(deep_mode, trig_sel));
  assign rel_v  = LVL_W'(xfc_pkg::release_level(deep_mode, trig_sel));
  assign above  = (fifo_level >= trig_v);
  assign below  = (fifo_level <= rel_v);

  always_comb begin
    req_n  = req_q;
    kind_n = kind_q;
    sent_n = sent_q;
    char_n = char_q;
    irq_n  = above;
    if (sw_clr) begin
      req_n  = 1'b0;
      kind_n = 1'b0;
      sent_n = 1'b0;
      char_n = '0;
      irq_n  = 1'b0;
    end else if (!fc_en) begin
      req_n = 1'b0;
    end else if (req_q) begin
      if (ins_ack) begin
        req_n  = 1'b0;
        sent_n = kind_q;
      end
    end else if (!sent_q && above) begin
      req_n  = 1'b1;
      kind_n = 1'b1;
      char_n = xoff_char;
    end else if (sent_q && below) begin
      req_n  = 1'b1;
      kind_n = 1'b0;
      char_n = xon_char;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      kind_q <= 1'b0;
      sent_q <= 1'b0;
      char_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      req_q  <= req_n;
      kind_q <= kind_n;
      sent_q <= sent_n;
      char_q <= char_n;
      irq_q  <= irq_n;
    end
  end

  assign ins_req  = req_q & fc_en;
  assign ins_char = char_q;
  assign rx_irq   = irq_q;
endmodule

// File: rtl/xfc_remote_rx.sv
module xfc_remote_rx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_clr,
  input  logic              fc_en,
  input  logic [1:0]        wlen,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              tx_char_busy,
  output logic              tx_pause
);
  logic [CHAR_W-1:0] mask;
  logic              hit_off, hit_on;
  logic              roff_q, roff_n;
  logic              pause_q, pause_n;

  assign mask    = CHAR_W'(xfc_pkg::char_mask(wlen));
  assign hit_off = ((rx_data & mask) == (xoff_char & mask));
  assign hit_on  = ((rx_data & mask) == (xon_char & mask));

  always_comb begin
    roff_n  = roff_q;
    pause_n = tx_char_busy ? pause_q : roff_q;
    if (sw_clr) begin
      roff_n  = 1'b0;
      pause_n = 1'b0;
    end else if (fc_en && rx_valid) begin
      if (hit_off)     roff_n = 1'b1;
      else if (hit_on) roff_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roff_q  <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      roff_q  <= roff_n;
      pause_q <= pause_n;
    end
  end

  assign tx_pause = pause_q & fc_en;
endmodule

// File: rtl/uart_xonxoff_ctrl.sv
module uart_xonxoff_ctrl #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_clr,
  input  logic             fc_en,
  input  logic             deep_mode,
  input  logic [1:0]       trig_sel,
  input  logic [1:0]       wlen,
  input  logic [7:0]       xon_char,
  input  logic [7:0]       xoff_char,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             tx_char_busy,
  input  logic             ins_ack,
  output logic             ins_req,
  output logic [7:0]       ins_char,
  output logic             tx_pause,
  output logic             rx_irq
);
  localparam int CHAR_W = 8;

  logic rst_int_n;

  xfc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  xfc_level_ctrl #(.LVL_W(LVL_W), .CHAR_W(CHAR_W)) u_level (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sw_clr     (sw_clr),
    .fc_en      (fc_en),
    .deep_mode  (deep_mode),
    .trig_sel   (trig_sel),
    .xon_char   (xon_char),
    .xoff_char  (xoff_char),
    .fifo_level (fifo_level),
    .ins_ack    (ins_ack),
    .ins_req    (ins_req),
    .ins_char   (ins_char),
    .rx_irq     (rx_irq)
  );

  xfc_remote_rx #(.CHAR_W(CHAR_W)) u_remote (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sw_clr       (sw_clr),
    .fc_en        (fc_en),
    .wlen         (wlen),
    .xon_char     (xon_char),
    .xoff_char    (xoff_char),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .tx_char_busy (tx_char_busy),
    .tx_pause     (tx_pause)
  );
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_clr,
  input logic             fc_en,
  input logic [LVL_W-1:0] fifo_level,
  input logic             tx_char_busy,
  input logic             ins_ack,
  input logic             ins_req,
  input logic [7:0]       ins_char,
  input logic             tx_pause,
  input logic             rx_irq
);
  // Pending insertion keeps its character until accepted.
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_ack && fc_en && !sw_clr) |=> (!fc_en || (ins_req && $stable(ins_char))));

  // An accepted request is not reissued in the following cycle.
  assert_one_per_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && ins_ack && !sw_clr) |=> !ins_req);

  // Pause only moves at character boundaries.
  assert_pause_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_char_busy && fc_en && !sw_clr) |=> (!fc_en || (tx_pause == $past(tx_pause))));

  // Empty FIFO never reaches any trigger.
  assert_empty_no_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == '0) |=> !rx_irq);

  // Clear empties the outputs.
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> (!ins_req && !tx_pause && !rx_irq));
endmodule

bind uart_xonxoff_ctrl xfc_checker #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/uart_xonxoff_ctrl_test.sv
`timescale 1ns/1ps
module uart_xonxoff_ctrl_test;
  localparam int LVL_W = 7;

  logic clk, rst_n, sw_clr, fc_en, deep_mode, rx_valid, tx_char_busy, ins_ack;
  logic [1:0] trig_sel, wlen;
  logic [7:0] xon_char, xoff_char, rx_data;
  logic [LVL_W-1:0] fifo_level;
  logic ins_req, tx_pause, rx_irq;
  logic [7:0] ins_char;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  uart_xonxoff_ctrl #(.LVL_W(LVL_W)) uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Independent tables from the requirements.
  function automatic int trig_of(input logic d, input logic [1:0] s);
    int t16[4] = '{1, 4, 8, 14};
    int t64[4] = '{8, 16, 56, 60};
    return d ? t64[s] : t16[s];
  endfunction
  function automatic int rel_of(input logic d, input logic [1:0] s);
    int r16[4] = '{0, 1, 4, 8};
    int r64[4] = '{0, 8, 16, 56};
    return d ? r64[s] : r16[s];
  endfunction
  function automatic logic [7:0] msk(input logic [1:0] w);
    return (8'd1 << (5 + w)) - 8'd1;
  endfunction

  // Reference model
  logic m_req, m_kind, m_sent, m_roff, m_pause, m_irq;
  logic [7:0] m_char;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req <= 0; m_kind <= 0; m_sent <= 0; m_roff <= 0; m_pause <= 0; m_irq <= 0; m_char <= 0;
    end else if (sw_clr) begin
      m_req <= 0; m_kind <= 0; m_sent <= 0; m_roff <= 0; m_pause <= 0; m_irq <= 0; m_char <= 0;
    end else begin
      m_irq <= (int'(fifo_level) >= trig_of(deep_mode, trig_sel));
      if (!fc_en) m_req <= 0;
      else if (m_req) begin
        if (ins_ack) begin m_req <= 0; m_sent <= m_kind; end
      end else if (!m_sent && int'(fifo_level) >= trig_of(deep_mode, trig_sel)) begin
        m_req <= 1; m_kind <= 1; m_char <= xoff_char;
      end else if (m_sent && int'(fifo_level) <= rel_of(deep_mode, trig_sel)) begin
        m_req <= 1; m_kind <= 0; m_char <= xon_char;
      end
      if (fc_en && rx_valid) begin
        if ((rx_data & msk(wlen)) == (xoff_char & msk(wlen))) m_roff <= 1;
        else if ((rx_data & msk(wlen)) == (xon_char & msk(wlen))) m_roff <= 0;
      end
      if (!tx_char_busy) m_pause <= m_roff;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk(ins_req === (m_req & fc_en), "R3/R4 ins_req", ins_req, m_req & fc_en);
    if (m_req & fc_en) chk(ins_char === m_char, "R5 ins_char", ins_char, m_char);
    chk(tx_pause === (m_pause & fc_en), "R7 tx_pause", tx_pause, m_pause & fc_en);
    chk(rx_irq === m_irq, "R1/R2 rx_irq", rx_irq, m_irq);
  endtask

  task automatic idle();
    sw_clr = 0; fc_en = 0; deep_mode = 0; trig_sel = 0; wlen = 2'd3;
    xon_char = 8'h11; xoff_char = 8'h13; fifo_level = 0; rx_valid = 0;
    rx_data = 0; tx_char_busy = 0; ins_ack = 0;
  endtask

  task automatic clear();
    sw_clr = 1; step(); sw_clr = 0;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step();
    // R11 reset state
    chk(ins_req == 0 && ins_char == 0 && tx_pause == 0 && rx_irq == 0, "R11 reset",
        {ins_req, tx_pause, rx_irq}, 0);

    // R1 / R2 trigger tables
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 4; s++) begin
        deep_mode = d[0]; trig_sel = s[1:0];
        fifo_level = LVL_W'(trig_of(d[0], s[1:0]) - 1); step();
        chk(rx_irq == 0, d ? "R2 below trigger" : "R1 below trigger", rx_irq, 0);
        fifo_level = LVL_W'(trig_of(d[0], s[1:0])); step();
        chk(rx_irq == 1, d ? "R2 at trigger" : "R1 at trigger", rx_irq, 1);
      end
    end
    fifo_level = 0; step();

    // R3 / R4 / R5 hysteresis, 16-entry, select 2 (trigger 8, release 4)
    fc_en = 1; deep_mode = 0; trig_sel = 2'd2; clear();
    fifo_level = 8; step();
    chk(ins_req && ins_char == 8'h13, "R3 xoff request", ins_char, 8'h13);
    xoff_char = 8'h55; step(); step();
    chk(ins_req && ins_char == 8'h13, "R5 held until ack", ins_char, 8'h13);
    xoff_char = 8'h13;
    ins_ack = 1; step(); ins_ack = 0;
    chk(ins_req == 0, "R5 drop after ack", ins_req, 0);
    step(); step();
    chk(ins_req == 0, "R3 once per crossing", ins_req, 0);
    fifo_level = 5; step();
    chk(ins_req == 0, "R4 above release", ins_req, 0);
    fifo_level = 4; step();
    chk(ins_req && ins_char == 8'h11, "R4 xon at release", ins_char, 8'h11);
    ins_ack = 1; step(); ins_ack = 0; fifo_level = 0; step();
    chk(ins_req == 0, "R4 no xon without xoff", ins_req, 0);

    // R4 64-entry release level, select 3 (trigger 60, release 56)
    deep_mode = 1; trig_sel = 2'd3; clear();
    fifo_level = 60; step(); ins_ack = 1; step(); ins_ack = 0;
    fifo_level = 57; step(); step();
    chk(ins_req == 0, "R4 deep above release", ins_req, 0);
    fifo_level = 56; step();
    chk(ins_req && ins_char == 8'h11, "R4 deep xon", ins_char, 8'h11);
    ins_ack = 1; step(); ins_ack = 0; fifo_level = 0; deep_mode = 0;

    // R6 word length masking: 5 bits, upper bits differ
    clear(); wlen = 2'd0;
    rx_valid = 1; rx_data = 8'hF3; step(); rx_valid = 0; step();
    chk(tx_pause == 1, "R6 masked xoff", tx_pause, 1);
    wlen = 2'd3; rx_valid = 1; rx_data = 8'hF1; step(); rx_valid = 0; step();
    chk(tx_pause == 1, "R6 8-bit mismatch ignored", tx_pause, 1);
    rx_valid = 1; rx_data = 8'h11; step(); rx_valid = 0; step();
    chk(tx_pause == 0, "R7 xon resumes", tx_pause, 0);
    // R7 Xoff wins when both equal
    xon_char = 8'h13; rx_valid = 1; rx_data = 8'h13; step(); rx_valid = 0; step();
    chk(tx_pause == 1, "R7 xoff precedence", tx_pause, 1);
    xon_char = 8'h11; clear();

    // R8 boundary
    tx_char_busy = 1; rx_valid = 1; rx_data = 8'h13; step(); rx_valid = 0;
    step(); step(); step();
    chk(tx_pause == 0, "R8 frozen while busy", tx_pause, 0);
    tx_char_busy = 0; step();
    chk(tx_pause == 1, "R8 applied at boundary", tx_pause, 1);

    // R9 disable retains pause state, ignores characters
    fc_en = 0; step();
    chk(tx_pause == 0, "R9 disabled no pause", tx_pause, 0);
    rx_valid = 1; rx_data = 8'h11; step(); rx_valid = 0;
    fifo_level = 14; step();
    chk(ins_req == 0, "R9 disabled no insert", ins_req, 0);
    fifo_level = 0; fc_en = 1; step();
    chk(tx_pause == 1, "R9 pause persists", tx_pause, 1);

    // R10 clear
    fifo_level = 14; step(); step();
    sw_clr = 1; step(); sw_clr = 0;
    chk(tx_pause == 0 && ins_req == 0 && rx_irq == 0, "R10 clear", {ins_req, tx_pause, rx_irq}, 0);
    fifo_level = 0; step();

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      int lv, dl;
      if ($urandom_range(0, 199) == 0) begin deep_mode = $urandom; trig_sel = $urandom; end
      if ($urandom_range(0, 99) == 0) wlen = $urandom;
      if ($urandom_range(0, 299) == 0) fc_en = ~fc_en;
      else if (!fc_en && $urandom_range(0, 19) == 0) fc_en = 1;
      sw_clr = ($urandom_range(0, 999) == 0);
      lv = int'(fifo_level);
      dl = $urandom_range(0, 4) - 2;
      lv = lv + dl;
      if (lv < 0) lv = 0;
      if (lv > (deep_mode ? 64 : 16)) lv = deep_mode ? 64 : 16;
      fifo_level = LVL_W'(lv);
      ins_ack = ($urandom_range(0, 9) < 3);
      tx_char_busy = ($urandom_range(0, 3) == 0);
      rx_valid = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 3))
        0: rx_data = (xon_char & msk(wlen)) | (8'($urandom) & ~msk(wlen));
        1: rx_data = (xoff_char & msk(wlen)) | (8'($urandom) & ~msk(wlen));
        default: rx_data = 8'($urandom);
      endcase
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule